// File: doc/BRIEF.md
# Address-Based Any-ASID TLB Invalidation Engine

A compact fully associative translation cache, paired with a port that removes every cached translation for one virtual page in a single operation. Each slot stores a virtual page number, an address-space identifier, a virtual machine identifier, a regime tag, a leaf flag, an XS attribute flag and a lock flag, along with its valid bit. A test-oriented fill port writes any slot directly.

An invalidate command carries a 32-bit operand whose upper twenty bits name the page, together with the target regime, a VMID with a flag that switches VMID comparison off, a leaf-only flag and an XS exclusion flag. The address-space identifier takes no part in the comparison. A masked key comparator builds the hit vector for all slots at once. The hit slots lose their valid bit on the accepting clock edge, and an acknowledge pulse follows, carrying the vector of cleared slots.

Top module: `tlb_inval_engine`

## Requirements
- R1: After reset, `valid_o` is all zero and `inv_ack_o` is low.
- R2: The page compared is `inv_op_i[31:12]`. Bits `[11:0]` of the operand have no effect on which slots are cleared.
- R3: A slot that matches in every other field is cleared, whatever ASID it holds.
- R4: A slot with its lock flag set keeps its valid bit through any invalidate.
- R5: When `inv_leaf_only_i` is 1, slots with leaf flag 0 are kept. When it is 0, matching slots of every level are cleared.
- R6: The slot's regime tag (0 = guest kernel, 1 = top privilege) must equal `inv_regime_i`. When `inv_no_vmid_i` is 0, the slot's VMID must equal `inv_vmid_i`.
- R7: When `inv_no_vmid_i` is 1, the VMID is not compared. This is the setting used for top-privilege commands.
- R8: When `inv_skip_xs_i` is 1, slots with XS flag 1 stay valid. When it is 0, the XS flag is not considered.
- R9: A request is accepted when `inv_req_i` is high and `inv_ack_o` is low. Every matching slot is cleared on that edge. `inv_ack_o` is high for exactly the next cycle, and `inv_hit_o` then shows the cleared slots (bit k = slot k).
- R10: While `inv_ack_o` is high, a request is not accepted and no slot is cleared.
- R11: If an accepted invalidate clears slot k on the same edge that the fill port writes slot k, slot k ends invalid.
- R12: All matching slots are cleared on the same edge.
- R13: A fill to slot `fill_idx_i` makes `valid_o` bit `fill_idx_i` read 1 after that edge, unless R11 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fill_en_i | input | 1 | Write one slot |
| fill_idx_i | input | 4 | Slot index to write |
| fill_vpn_i | input | 20 | Virtual page number |
| fill_asid_i | input | 8 | Address-space identifier |
| fill_vmid_i | input | 8 | Virtual machine identifier |
| fill_regime_i | input | 1 | Regime tag: 0 guest kernel, 1 top privilege |
| fill_leaf_i | input | 1 | 1 = leaf translation |
| fill_xs_i | input | 1 | XS attribute |
| fill_lock_i | input | 1 | 1 = protected from invalidation |
| inv_req_i | input | 1 | Invalidate request |
| inv_op_i | input | 32 | Operand; page in [31:12] |
| inv_regime_i | input | 1 | Target regime |
| inv_vmid_i | input | 8 | VMID to compare |
| inv_no_vmid_i | input | 1 | 1 = skip the VMID comparison |
| inv_leaf_only_i | input | 1 | 1 = only clear leaf slots |
| inv_skip_xs_i | input | 1 | 1 = keep slots with XS set |
| inv_ack_o | output | 1 | One-cycle done pulse |
| inv_hit_o | output | 16 | Slots cleared by the last accepted request |
| valid_o | output | 16 | Valid bit of each slot |

## Verification
Invalidation clears slots on the accepting edge, so `valid_o`, `inv_ack_o` and `inv_hit_o` are all due one register stage after the request is presented. The bench drives the request at a falling edge and samples 1 ns after the next rising edge. It samples again one cycle later to confirm that the acknowledge has dropped. A fill becomes visible on `valid_o` one edge after it is driven. For the handshake test, the request is held across three edges: the bench expects an accept, then a refused cycle in which a re-filled matching slot survives, then a second accept that clears that slot.

// File: rtl/tlb_inval_pkg.sv
package tlb_inval_pkg;
  localparam int VPN_W      = 20;
  localparam int ASID_W     = 8;
  localparam int VMID_W     = 8;
  localparam int OP_W       = 32;
  localparam int PAGE_SHIFT = OP_W - VPN_W;

  typedef enum logic {
    RGM_GUEST = 1'b0,
    RGM_TOP   = 1'b1
  } regime_e;

  // comparable part of a slot
  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [VMID_W-1:0] vmid;
    regime_e           regime;
  } tlb_key_t;

  localparam int KEY_W = $bits(tlb_key_t);

  typedef struct packed {
    tlb_key_t key;
    logic     leaf;
    logic     xs;
    logic     lock;
  } tlb_entry_t;

  typedef struct packed {
    tlb_key_t key;
    tlb_key_t care;
    logic     leaf_only;
    logic     skip_xs;
  } inv_cmd_t;
endpackage

// File: rtl/tlb_inval_decode.sv
module tlb_inval_decode
  import tlb_inval_pkg::*;
(
  input  logic [OP_W-1:0]   op_i,
  input  logic              regime_i,
  input  logic [VMID_W-1:0] vmid_i,
  input  logic              no_vmid_i,
  input  logic              leaf_only_i,
  input  logic              skip_xs_i,
  output inv_cmd_t          cmd_o
);
  logic unused_rsvd;
  assign unused_rsvd = ^op_i[PAGE_SHIFT-1:0];

  always_comb begin
    cmd_o = '0;
    cmd_o.key.vpn     = op_i[OP_W-1:PAGE_SHIFT];
    cmd_o.key.asid    = '0;
    cmd_o.key.vmid    = vmid_i;
    cmd_o.key.regime  = regime_e'(regime_i);
    // care mask: asid never compared, vmid optional
    cmd_o.care.vpn    = '1;
    cmd_o.care.asid   = '0;
    cmd_o.care.vmid   = no_vmid_i ? '0 : '1;
    cmd_o.care.regime = regime_e'(1'b1);
    cmd_o.leaf_only   = leaf_only_i;
    cmd_o.skip_xs     = skip_xs_i;
  end
endmodule

// File: rtl/tlb_inval_match.sv
module tlb_inval_match
  import tlb_inval_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  tlb_entry_t [NUM_ENTRIES-1:0] ent_i,
  input  logic       [NUM_ENTRIES-1:0] valid_i,
  input  inv_cmd_t                     cmd_i,
  output logic       [NUM_ENTRIES-1:0] hit_o
);
  for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_cmp
    logic [KEY_W-1:0] diff;
    logic key_ok, lvl_ok, attr_ok;
    assign diff    = (ent_i[k].key ^ cmd_i.key) & cmd_i.care;
    assign key_ok  = (diff == '0);
    assign lvl_ok  = ~cmd_i.leaf_only | ent_i[k].leaf;
    assign attr_ok = ~cmd_i.skip_xs | ~ent_i[k].xs;
    assign hit_o[k] = valid_i[k] & ~ent_i[k].lock & key_ok & lvl_ok & attr_ok;
  end
endmodule

// File: rtl/tlb_inval_array.sv
module tlb_inval_array
  import tlb_inval_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         fill_en_i,
  input  logic       [IDX_W-1:0]       fill_idx_i,
  input  tlb_entry_t                   fill_ent_i,
  input  logic       [NUM_ENTRIES-1:0] clr_i,
  input  logic                         accept_i,
  output tlb_entry_t [NUM_ENTRIES-1:0] ent_o,
  output logic       [NUM_ENTRIES-1:0] valid_o
);
  logic [NUM_ENTRIES-1:0] fill_we;

  for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_slot
    tlb_entry_t ent_q;
    logic       valid_q;

    assign fill_we[k] = fill_en_i & (fill_idx_i == IDX_W'(k));

    always_ff @(posedge clk_i) begin
      if (fill_we[k]) ent_q <= fill_ent_i;
    end

    // clear beats fill
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         valid_q <= 1'b0;
      else if (clr_i[k])   valid_q <= 1'b0;
      else if (fill_we[k]) valid_q <= 1'b1;
    end

    assign ent_o[k]   = ent_q;
    assign valid_o[k] = valid_q;

    AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_q && ent_q.lock && !fill_we[k] |=> valid_q); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_q && !accept_i && !fill_we[k] |=> valid_q); // R10
    AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fill_we[k] && clr_i[k] |=> !valid_q); // R11
    AST_FILL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fill_we[k] && !clr_i[k] |=> valid_q); // R13
  end
endmodule

// File: rtl/tlb_inval_ctrl.sv
module tlb_inval_ctrl #(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic [NUM_ENTRIES-1:0] hit_i,
  output logic                   accept_o,
  output logic [NUM_ENTRIES-1:0] clr_o,
  output logic                   ack_o,
  output logic [NUM_ENTRIES-1:0] hit_o
);
  logic                   ack_q;
  logic [NUM_ENTRIES-1:0] hit_q;

  assign accept_o = req_i & ~ack_q;
  assign clr_o    = hit_i & {NUM_ENTRIES{accept_o}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      hit_q <= '0;
    end else begin
      ack_q <= accept_o;
      if (accept_o) hit_q <= hit_i;
    end
  end

  assign ack_o = ack_q;
  assign hit_o = hit_q;

  AST_ACK_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !ack_q |=> ack_q); // R9
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |=> !ack_q); // R10
  AST_HIT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |=> $stable(hit_q)); // R9
endmodule

// File: rtl/tlb_inval_engine.sv
module tlb_inval_engine
  import tlb_inval_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   fill_en_i,
  input  logic [IDX_W-1:0]       fill_idx_i,
  input  logic [VPN_W-1:0]       fill_vpn_i,
  input  logic [ASID_W-1:0]      fill_asid_i,
  input  logic [VMID_W-1:0]      fill_vmid_i,
  input  logic                   fill_regime_i,
  input  logic                   fill_leaf_i,
  input  logic                   fill_xs_i,
  input  logic                   fill_lock_i,
  input  logic                   inv_req_i,
  input  logic [OP_W-1:0]        inv_op_i,
  input  logic                   inv_regime_i,
  input  logic [VMID_W-1:0]      inv_vmid_i,
  input  logic                   inv_no_vmid_i,
  input  logic                   inv_leaf_only_i,
  input  logic                   inv_skip_xs_i,
  output logic                   inv_ack_o,
  output logic [NUM_ENTRIES-1:0] inv_hit_o,
  output logic [NUM_ENTRIES-1:0] valid_o
);
  tlb_entry_t                   fill_ent;
  tlb_entry_t [NUM_ENTRIES-1:0] ent;
  inv_cmd_t                     cmd;
  logic [NUM_ENTRIES-1:0]       hit, clr;
  logic                         accept;

  always_comb begin
    fill_ent.key.vpn    = fill_vpn_i;
    fill_ent.key.asid   = fill_asid_i;
    fill_ent.key.vmid   = fill_vmid_i;
    fill_ent.key.regime = regime_e'(fill_regime_i);
    fill_ent.leaf       = fill_leaf_i;
    fill_ent.xs         = fill_xs_i;
    fill_ent.lock       = fill_lock_i;
  end

  tlb_inval_decode u_decode (
    .op_i        (inv_op_i),
    .regime_i    (inv_regime_i),
    .vmid_i      (inv_vmid_i),
    .no_vmid_i   (inv_no_vmid_i),
    .leaf_only_i (inv_leaf_only_i),
    .skip_xs_i   (inv_skip_xs_i),
    .cmd_o       (cmd)
  );

  tlb_inval_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
    .ent_i   (ent),
    .valid_i (valid_o),
    .cmd_i   (cmd),
    .hit_o   (hit)
  );

  tlb_inval_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (inv_req_i),
    .hit_i    (hit),
    .accept_o (accept),
    .clr_o    (clr),
    .ack_o    (inv_ack_o),
    .hit_o    (inv_hit_o)
  );

  tlb_inval_array #(.NUM_ENTRIES(NUM_ENTRIES)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fill_en_i  (fill_en_i),
    .fill_idx_i (fill_idx_i),
    .fill_ent_i (fill_ent),
    .clr_i      (clr),
    .accept_i   (accept),
    .ent_o      (ent),
    .valid_o    (valid_o)
  );

  for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_chk
    logic no_fill;
    assign no_fill = !(fill_en_i && fill_idx_i == IDX_W'(k));
    AST_NONLEAF_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept && inv_leaf_only_i && valid_o[k] && !ent[k].leaf && no_fill |=> valid_o[k]); // R5
    AST_XS_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept && inv_skip_xs_i && valid_o[k] && ent[k].xs && no_fill |=> valid_o[k]); // R8
    AST_OTHER_REGIME_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept && valid_o[k] && (ent[k].key.regime != regime_e'(inv_regime_i)) && no_fill
      |=> valid_o[k]); // R6
  end
endmodule

// File: tb/tb_tlb_inval_engine.sv
module tb_tlb_inval_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fill_en_i = 1'b0;
  logic [3:0]  fill_idx_i = '0;
  logic [19:0] fill_vpn_i = '0;
  logic [7:0]  fill_asid_i = '0;
  logic [7:0]  fill_vmid_i = '0;
  logic        fill_regime_i = 1'b0;
  logic        fill_leaf_i = 1'b0;
  logic        fill_xs_i = 1'b0;
  logic        fill_lock_i = 1'b0;
  logic        inv_req_i = 1'b0;
  logic [31:0] inv_op_i = '0;
  logic        inv_regime_i = 1'b0;
  logic [7:0]  inv_vmid_i = '0;
  logic        inv_no_vmid_i = 1'b0;
  logic        inv_leaf_only_i = 1'b0;
  logic        inv_skip_xs_i = 1'b0;
  logic        inv_ack_o;
  logic [15:0] inv_hit_o;
  logic [15:0] valid_o;

  int total = 0;
  int bad = 0;
  logic [15:0] shadow = '0;

  always #5 clk_i = ~clk_i;

  tlb_inval_engine dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_fill(input int idx, input logic [19:0] vpn, input logic [7:0] asid,
                            input logic [7:0] vmid, input logic rgm, input logic leaf,
                            input logic xs, input logic lock);
    fill_en_i = 1'b1; fill_idx_i = 4'(idx); fill_vpn_i = vpn; fill_asid_i = asid;
    fill_vmid_i = vmid; fill_regime_i = rgm; fill_leaf_i = leaf; fill_xs_i = xs;
    fill_lock_i = lock;
  endtask

  task automatic do_fill(input int idx, input logic [19:0] vpn, input logic [7:0] asid,
                         input logic [7:0] vmid, input logic rgm, input logic leaf,
                         input logic xs, input logic lock);
    @(negedge clk_i);
    drive_fill(idx, vpn, asid, vmid, rgm, leaf, xs, lock);
    @(posedge clk_i); #1;
    fill_en_i = 1'b0;
    shadow[idx] = 1'b1;
    chk(valid_o[idx] === 1'b1, "R13 fill", 32'(valid_o), 32'(shadow));
  endtask

  task automatic drive_inv(input logic [31:0] op, input logic rgm, input logic [7:0] vmid,
                           input logic novm, input logic lo, input logic sx);
    inv_req_i = 1'b1; inv_op_i = op; inv_regime_i = rgm; inv_vmid_i = vmid;
    inv_no_vmid_i = novm; inv_leaf_only_i = lo; inv_skip_xs_i = sx;
  endtask

  task automatic do_inv(input logic [31:0] op, input logic rgm, input logic [7:0] vmid,
                        input logic novm, input logic lo, input logic sx,
                        input logic [15:0] exp, input string tag);
    @(negedge clk_i);
    drive_inv(op, rgm, vmid, novm, lo, sx);
    @(posedge clk_i); #1;
    inv_req_i = 1'b0;
    shadow = shadow & ~exp;
    chk(inv_ack_o === 1'b1, "R9 ack after accept", 32'(inv_ack_o), 1);
    chk(inv_hit_o === exp, tag, 32'(inv_hit_o), 32'(exp));
    chk(valid_o === shadow, tag, 32'(valid_o), 32'(shadow));
    @(posedge clk_i); #1;
    chk(inv_ack_o === 1'b0, "R9 ack single pulse", 32'(inv_ack_o), 0);
  endtask

  task automatic t_reset();
    chk(valid_o === 16'h0, "R1 valid clear", 32'(valid_o), 0);
    chk(inv_ack_o === 1'b0, "R1 ack low", 32'(inv_ack_o), 0);
  endtask

  task automatic t_page_asid();
    do_fill(0, 20'h12345, 8'd1, 8'd5, 1'b0, 1'b1, 1'b0, 1'b0);
    do_fill(1, 20'h12345, 8'd2, 8'd5, 1'b0, 1'b1, 1'b0, 1'b0);
    do_fill(2, 20'h12345, 8'd3, 8'd5, 1'b0, 1'b1, 1'b0, 1'b1);
    do_fill(3, 20'h12345, 8'd1, 8'd5, 1'b0, 1'b0, 1'b0, 1'b0);
    do_fill(4, 20'h12345, 8'd1, 8'd6, 1'b0, 1'b1, 1'b0, 1'b0);
    do_fill(5, 20'h12345, 8'd1, 8'd0, 1'b1, 1'b1, 1'b0, 1'b0);
    do_fill(6, 20'h12346, 8'd1, 8'd5, 1'b0, 1'b1, 1'b0, 1'b0);
    do_fill(7, 20'h12345, 8'd9, 8'd3, 1'b1, 1'b1, 1'b0, 1'b0);
    // R2 R3 R12: low operand bits set, two ASIDs cleared on one edge
    do_inv(32'h12345ABC, 1'b0, 8'd5, 1'b0, 1'b1, 1'b0, 16'h0003, "R3 R12 any ASID");
    chk(valid_o[2] === 1'b1, "R4 locked kept", 32'(valid_o[2]), 1);
    chk(valid_o[6] === 1'b1, "R2 other page kept", 32'(valid_o[6]), 1);
  endtask

  task automatic t_level();
    do_inv(32'h12345000, 1'b0, 8'd5, 1'b0, 1'b0, 1'b0, 16'h0008, "R5 all levels");
  endtask

  task automatic t_vmid_regime();
    do_inv(32'h12345FFF, 1'b0, 8'd6, 1'b0, 1'b1, 1'b0, 16'h0010, "R6 vmid match");
    do_inv(32'h12345000, 1'b1, 8'd77, 1'b1, 1'b1, 1'b0, 16'h00A0, "R7 vmid ignored");
    chk(valid_o[2] === 1'b1, "R4 locked kept", 32'(valid_o[2]), 1);
  endtask

  task automatic t_xs();
    do_fill(8, 20'h00ABC, 8'd1, 8'd5, 1'b0, 1'b1, 1'b1, 1'b0);
    do_fill(9, 20'h00ABC, 8'd1, 8'd5, 1'b0, 1'b1, 1'b0, 1'b0);
    do_inv(32'h00ABC000, 1'b0, 8'd5, 1'b0, 1'b1, 1'b1, 16'h0200, "R8 skip xs");
    do_inv(32'h00ABC000, 1'b0, 8'd5, 1'b0, 1'b1, 1'b0, 16'h0100, "R8 all attrs");
  endtask

  task automatic t_collide();
    do_fill(10, 20'h0F00F, 8'd1, 8'd5, 1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk_i);
    drive_fill(10, 20'h0F00F, 8'd4, 8'd5, 1'b0, 1'b1, 1'b0, 1'b0);
    drive_inv(32'h0F00F000, 1'b0, 8'd5, 1'b0, 1'b1, 1'b0);
    @(posedge clk_i); #1;
    inv_req_i = 1'b0; fill_en_i = 1'b0;
    shadow[10] = 1'b0;
    chk(valid_o[10] === 1'b0, "R11 invalidate wins", 32'(valid_o[10]), 0);
    chk(inv_hit_o === 16'h0400, "R11 hit vector", 32'(inv_hit_o), 32'h400);
    @(posedge clk_i); #1;
  endtask

  task automatic t_pending();
    do_fill(12, 20'h00777, 8'd1, 8'd5, 1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk_i);
    drive_inv(32'h00777000, 1'b0, 8'd5, 1'b0, 1'b1, 1'b0);
    @(posedge clk_i); #1;
    chk(inv_ack_o === 1'b1 && valid_o[12] === 1'b0, "R9 first accept",
        {15'd0, inv_ack_o, valid_o}, {16'd1, 16'h0});
    @(negedge clk_i);
    drive_fill(12, 20'h00777, 8'd2, 8'd5, 1'b0, 1'b1, 1'b0, 1'b0);
    @(posedge clk_i); #1;
    chk(inv_ack_o === 1'b0, "R10 no accept while ack", 32'(inv_ack_o), 0);
    chk(valid_o[12] === 1'b1, "R10 refill survives", 32'(valid_o[12]), 1);
    @(negedge clk_i);
    fill_en_i = 1'b0;
    @(posedge clk_i); #1;
    chk(inv_ack_o === 1'b1 && valid_o[12] === 1'b0, "R10 second accept",
        {15'd0, inv_ack_o, valid_o}, {16'd1, 16'h0});
    inv_req_i = 1'b0;
    shadow[12] = 1'b0;
    @(posedge clk_i); #1;
    chk(valid_o === shadow, "R10 final state", 32'(valid_o), 32'(shadow));
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    t_reset();
    t_page_asid();
    t_level();
    t_vmid_regime();
    t_xs();
    t_collide();
    t_pending();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule